// File: doc/BRIEF.md
# Compare Timer with Enable, Mask and Status

This block is a compare timer that watches a free-running system count supplied from outside. Software programs a 64-bit compare value, either directly or as a 32-bit signed distance from the present count. The block reports whether the count has reached the compare value, and raises a level interrupt when the timer is enabled and not masked.

The access port is a single-cycle write strobe with a combinational read. Three locations are decoded: address 0 is the control word, address 1 is the compare value, and address 2 is the timer-value view. Address 3 reads zero. Clearing the enable gates only the interrupt and the status bit. The timer-value view goes on counting down.

Top module: `vtimer_ctl`

## Requirements
- R1: The control word at address 0 reads bit 0 = enable, bit 1 = mask and bit 2 = status, with bits 63:3 reading zero. Writes to address 0 store only bits 1:0; the values written to bit 2 and bits 63:3 are dropped.
- R2: While enabled, status is 1 exactly when (count − compare), taken as a signed 64-bit value, is zero or positive. The mask value has no effect on status.
- R3: While disabled, status reads 0 whatever the count and compare values are.
- R4: The interrupt output is a register. After each clock edge it equals enable AND condition AND NOT mask, as they stood before that edge. A write to control or compare therefore reaches the interrupt one cycle later.
- R5: Address 1 reads back the full 64-bit compare value, and a write to address 1 replaces it.
- R6: Address 2 reads the low 32 bits of (compare − count) on bits 31:0, with bits 63:32 reading zero.
- R7: A write to address 2 sets compare to count + the sign-extended wdata[31:0], using the count present in the write cycle.
- R8: The timer-value view keeps following the count while the timer is disabled.
- R9: After reset, enable, mask, compare and the interrupt are all 0.
- R10: Address 3 reads zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_count | input | CNT_W | Free-running system count |
| acc_we | input | 1 | Write strobe, sampled at the rising clock edge |
| acc_addr | input | 2 | Register select: 0 control, 1 compare, 2 timer value |
| acc_wdata | input | CNT_W | Write data |
| acc_rdata | output | CNT_W | Combinational read data for acc_addr |
| irq_o | output | 1 | Registered level interrupt |

## Verification
A control write and a change in the compare condition can land in the same cycle. The bench provokes this by moving the count onto the compare value in the same cycle that it writes enable. It then checks that status reads 1 at once, that the interrupt is still 0 after that edge, and that the interrupt rises one edge later. The bench also writes a zero timer value, which makes the condition true through the write itself, and changes the mask while the condition holds. In each case the interrupt is judged against the state as it stood before each edge.

// File: rtl/vtimer_ctl.sv
module vtimer_ctl #(
  parameter int CNT_W = 64,
  parameter int TV_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] sys_count,
  input  logic             acc_we,
  input  logic [1:0]       acc_addr,
  input  logic [CNT_W-1:0] acc_wdata,
  output logic [CNT_W-1:0] acc_rdata,
  output logic             irq_o
);
  localparam logic [1:0] A_CTL = 2'd0;
  localparam logic [1:0] A_CMP = 2'd1;
  localparam logic [1:0] A_TV  = 2'd2;
  localparam int         EXT_W = CNT_W - TV_W;

  logic             en_q, mask_q, irq_q;
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] elapsed;
  logic [TV_W-1:0]  remain;
  logic [CNT_W-1:0] tv_ext;
  logic             cond, status;

  assign elapsed = sys_count - cmp_q;
  assign cond    = ~elapsed[CNT_W-1];
  assign status  = en_q & cond;
  assign remain  = cmp_q[TV_W-1:0] - sys_count[TV_W-1:0];
  assign tv_ext  = {{EXT_W{acc_wdata[TV_W-1]}}, acc_wdata[TV_W-1:0]};
  assign irq_o   = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= 1'b0;
      cmp_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= status & ~mask_q;
      if (acc_we) begin
        case (acc_addr)
          A_CTL: begin
            en_q   <= acc_wdata[0];
            mask_q <= acc_wdata[1];
          end
          A_CMP:   cmp_q <= acc_wdata;
          A_TV:    cmp_q <= sys_count + tv_ext;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    acc_rdata = '0;
    case (acc_addr)
      A_CTL:   acc_rdata[2:0] = {status, mask_q, en_q};
      A_CMP:   acc_rdata = cmp_q;
      A_TV:    acc_rdata[TV_W-1:0] = remain;
      default: acc_rdata = '0;
    endcase
  end
endmodule

module vtimer_ctl_chk #(
  parameter int CNT_W = 64,
  parameter int TV_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] sys_count,
  input logic             acc_we,
  input logic [1:0]       acc_addr,
  input logic [CNT_W-1:0] acc_wdata,
  input logic [CNT_W-1:0] acc_rdata,
  input logic             irq_o,
  input logic             en_q,
  input logic             mask_q,
  input logic [CNT_W-1:0] cmp_q
);
  logic [CNT_W-1:0] gap;
  logic [CNT_W-1:0] want_cmp;
  logic             reached;
  assign gap      = sys_count - cmp_q;
  assign reached  = !gap[CNT_W-1];
  assign want_cmp = sys_count + CNT_W'($signed(acc_wdata[TV_W-1:0]));

  // R4
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !mask_q && reached) |=> irq_o);
  // R4
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q || mask_q || !reached) |=> !irq_o);
  // R1
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr == 2'd0) |-> (acc_rdata[CNT_W-1:3] == '0));
  // R2
  status_nomask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr == 2'd0 && en_q) |-> (acc_rdata[2] == reached));
  // R3
  status_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr == 2'd0 && !en_q) |-> !acc_rdata[2]);
  // R7
  tv_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_we && acc_addr == 2'd2) |=> (cmp_q == $past(want_cmp)));
  // R10
  addr3_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr == 2'd3) |-> (acc_rdata == '0));
endmodule

bind vtimer_ctl vtimer_ctl_chk #(.CNT_W(CNT_W), .TV_W(TV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_count(sys_count), .acc_we(acc_we),
  .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
  .irq_o(irq_o), .en_q(en_q), .mask_q(mask_q), .cmp_q(cmp_q)
);

// File: tb/sim_vtimer_ctl.sv
`timescale 1ns/1ps
module sim_vtimer_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] sys_count = '0;
  logic        acc_we = 1'b0;
  logic [1:0]  acc_addr = '0;
  logic [63:0] acc_wdata = '0;
  logic [63:0] acc_rdata;
  logic        irq_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vtimer_ctl u0 (.clk(clk), .rst_n(rst_n), .sys_count(sys_count), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .irq_o(irq_o));

  localparam int NV = 7;
  localparam logic [63:0] V_CNT [NV] = '{64'd100, 64'd99, 64'd200, 64'd200, 64'd5,
                                        64'h8000_0000_0000_0000, 64'd0};
  localparam logic [63:0] V_CMP [NV] = '{64'd100, 64'd100, 64'd100, 64'd100,
                                        64'hFFFF_FFFF_FFFF_FFF0, 64'd0, 64'h7FFF_FFFF_FFFF_FFFF};
  localparam logic [1:0]  V_CTL [NV] = '{2'b01, 2'b01, 2'b11, 2'b00, 2'b01, 2'b01, 2'b01};
  localparam logic        V_ST  [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic        V_IRQ [NV] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    acc_we = 1'b1; acc_addr = a; acc_wdata = d;
    @(posedge clk);
    @(negedge clk);
    acc_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [63:0] d);
    acc_addr = a;
    #1 d = acc_rdata;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] r;
    repeat (3) @(negedge clk);
    // R9 reset state
    rd(2'd0, r); check("R9 ctrl", r, 64'd0);
    rd(2'd1, r); check("R9 cmp", r, 64'd0);
    check("R9 irq", {63'd0, irq_o}, 64'd0);
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < NV; i++) begin
      sys_count = V_CNT[i];
      wr(2'd1, V_CMP[i]);
      wr(2'd0, 64'hFFFF_FFFF_FFFF_FFF8 | {62'd0, V_CTL[i]});
      tick();
      rd(2'd0, r);
      check("R1 rsv/bit2", {r[63:3], 3'b000} | {62'd0, r[1:0]}, {62'd0, V_CTL[i]});
      check(V_CTL[i][0] ? "R2 status" : "R3 status", {63'd0, r[2]}, {63'd0, V_ST[i]});
      check("R4 irq", {63'd0, irq_o}, {63'd0, V_IRQ[i]});
    end

    // R5 compare readback
    wr(2'd1, 64'hDEAD_BEEF_0123_4567);
    rd(2'd1, r); check("R5 cmp", r, 64'hDEAD_BEEF_0123_4567);

    // R6 timer value view
    wr(2'd0, 64'd0);
    wr(2'd1, 64'd1000); sys_count = 64'd400;
    rd(2'd2, r); check("R6 tval pos", r, 64'd600);
    sys_count = 64'd1200;
    rd(2'd2, r); check("R6 tval neg", r, 64'h0000_0000_FFFF_FF38);

    // R8 counts while disabled
    sys_count = 64'd450;
    rd(2'd2, r); check("R8 tval disabled", r, 64'd550);
    tick(); check("R8 irq off", {63'd0, irq_o}, 64'd0);

    // R7 timer value write
    sys_count = 64'd50;
    wr(2'd2, 64'hAAAA_AAAA_0000_0019);
    rd(2'd1, r); check("R7 cmp pos", r, 64'd75);
    sys_count = 64'h1_0000_0000;
    wr(2'd2, 64'h0000_0000_FFFF_FFFF);
    rd(2'd1, r); check("R7 cmp neg", r, 64'h0000_0000_FFFF_FFFF);

    // R10 address 3
    wr(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(2'd3, r); check("R10 read", r, 64'd0);
    rd(2'd1, r); check("R10 cmp kept", r, 64'h0000_0000_FFFF_FFFF);
    rd(2'd0, r); check("R10 ctrl kept", r, 64'd0);

    // same cycle: enable write and condition becoming true (R4)
    wr(2'd1, 64'd500); sys_count = 64'd499;
    @(negedge clk);
    sys_count = 64'd500; acc_we = 1'b1; acc_addr = 2'd0; acc_wdata = 64'd1;
    @(posedge clk); @(negedge clk); acc_we = 1'b0;
    rd(2'd0, r); check("R2 status same cycle", {63'd0, r[2]}, 64'd1);
    check("R4 irq lag", {63'd0, irq_o}, 64'd0);
    tick(); check("R4 irq rise", {63'd0, irq_o}, 64'd1);

    // mask set while condition holds: status stays, irq falls a cycle later (R2, R4)
    wr(2'd0, 64'd3);
    rd(2'd0, r); check("R2 status masked", {63'd0, r[2]}, 64'd1);
    check("R4 irq still high", {63'd0, irq_o}, 64'd1);
    tick(); check("R4 irq masked", {63'd0, irq_o}, 64'd0);

    // zero timer-value write makes condition true through the write (R7, R4)
    wr(2'd0, 64'd1);
    sys_count = 64'd10; wr(2'd1, 64'd20);
    tick(); check("R4 irq before", {63'd0, irq_o}, 64'd0);
    wr(2'd2, 64'd0);
    rd(2'd0, r); check("R7 status after tv=0", {63'd0, r[2]}, 64'd1);
    tick(); check("R4 irq after tv=0", {63'd0, irq_o}, 64'd1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule